// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block is the register front end of an I/O interrupt routing controller. Software sees two locations only: a select register and a data window. The value in the select register decides which internal register a window access reaches. The targets are an identification register, a read-only version register, an arbitration register that mirrors the identification value, and a table of 64-bit per-pin routing entries. Each routing entry is read and written as two 32-bit halves, and the low bit of the select value picks the half.

The bus port is a plain single-cycle register port. It carries an address, a write strobe, write data and a byte-length code. Read data is combinational and is masked to the access length. The routing entries leave the block as one flat vector. A sequencer checks every table write. When the written entry is level-triggered and its pin is requesting, the sequencer raises a one-cycle service request that names the pin. A downstream delivery stage can mark an entry remote-pending through a set strobe.

The sequencer has three states. `SV_IDLE` waits for a table write. A table write moves it to `SV_CHECK`, and the index written is latched. From `SV_CHECK` it goes to `SV_FIRE` when the latched entry is level-triggered and its pin is requesting. If not, it goes back to `SV_CHECK` on a new table write, or to `SV_IDLE` otherwise. `SV_FIRE` drives the service request for one cycle. It then goes to `SV_CHECK` on a new table write, or to `SV_IDLE` otherwise.

Top module: `irq_regwin`

## Requirements
- R1: Address offset 0x00 is the select register. A write stores the low 8 bits of the write data. A read returns the select value in bits 7:0 and zero in all other bits.
- R2: Select value 0x01 is the version register. A window read returns NPINS-1 in bits 23:16 and VER_CODE in bits 7:0, with zero elsewhere (0x00170020 by default). Window writes to it change nothing.
- R3: Select value 0x00 is the identification register, a 4-bit value held in bits 27:24. A window write stores data bits 27:24. Select value 0x02 reads the same value, and window writes to select 0x02 change nothing.
- R4: For select values of 0x10 and above, the table index is (select-0x10)>>1. An odd select reaches entry bits 63:32 and an even select reaches bits 31:0, for both reads and writes.
- R5: Select values 0x03 to 0x0F, and table indexes of NPINS or more, read as 0xFFFFFFFF. Window writes to them change no state.
- R6: A write to the low half of an entry stores bit 14 (remote-pending) as 0, whatever the data holds. A high-half write leaves bit 14 unchanged. A pulse on rset_valid sets bit 14 of entry rset_idx.
- R7: After any write to a valid table half, the sequencer checks the entry. If entry bit 15 is 1 (level) and pin_req is set for that pin, svc_req is high for exactly one cycle, and svc_pin holds the index. svc_req is high in the second cycle after the write edge. If either condition fails, svc_req stays low.
- R8: After reset, every entry holds 0x0000000000010000, so only the mask bit 16 is set. The select and identification registers are zero.
- R9: Only bus_addr[7:0] is decoded, so higher address bits are ignored. Any offset other than 0x00 and 0x10 reads as zero and ignores writes.
- R10: bus_len selects the access size: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. Write data and read data are both masked to that many low-order bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| bus_wdata | input | 32 | Write data |
| bus_len | input | 2 | Access size code |
| bus_rdata | output | 32 | Combinational read data |
| pin_req | input | NPINS | Per-pin request levels |
| rset_valid | input | 1 | Set remote-pending strobe |
| rset_idx | input | IDX_W | Entry index for rset_valid |
| ent_flat | output | NPINS*64 | All routing entries, entry i at bits [64*i+63:64*i] |
| svc_req | output | 1 | One-cycle service request |
| svc_pin | output | IDX_W | Pin to service |

## Verification
The assertions assume two things about the inputs. First, the bus gives one access per strobe with a stable address and stable data. Second, a rset_valid pulse never lands in the same cycle as a write whose stability is being checked. Under these assumptions, out-of-range writes, read-only writes and foreign-offset writes can be checked for leaving the state unchanged. The stimulus drives only one of the bus strobe and rset_valid at a time. It keeps pin_req at zero except in the service section, so table writes made during the sweeps cannot raise extra service requests.

// File: rtl/regwin_pkg.sv
`timescale 1ns/1ps
package regwin_pkg;
    localparam logic [7:0] OFS_SEL = 8'h00;
    localparam logic [7:0] OFS_WIN = 8'h10;
    localparam logic [7:0] SEL_ID  = 8'h00;
    localparam logic [7:0] SEL_VER = 8'h01;
    localparam logic [7:0] SEL_ARB = 8'h02;
    localparam logic [7:0] SEL_TBL = 8'h10;

    localparam int BIT_RPEND = 14;
    localparam int BIT_LEVEL = 15;
    localparam int BIT_MASK  = 16;
    localparam logic [63:0] ENT_RESET = 64'h0000_0000_0001_0000;

    typedef enum logic [1:0] {
        SV_IDLE  = 2'd0,
        SV_CHECK = 2'd1,
        SV_FIRE  = 2'd2
    } svc_state_t;

    function automatic logic [31:0] len_mask(input logic [1:0] len);
        case (len)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/regwin_decode.sv
`timescale 1ns/1ps
module regwin_decode #(
    parameter int NPINS = 24,
    parameter int IDX_W = $clog2(NPINS)
) (
    input  logic [7:0]       sel,
    output logic             is_id,
    output logic             is_ver,
    output logic             is_arb,
    output logic             tbl_valid,
    output logic             tbl_hi,
    output logic [IDX_W-1:0] tbl_idx
);
    import regwin_pkg::*;

    logic [7:0] raw_idx;

    always_comb begin
        raw_idx   = 8'(sel - SEL_TBL) >> 1;
        is_id     = (sel == SEL_ID);
        is_ver    = (sel == SEL_VER);
        is_arb    = (sel == SEL_ARB);
        tbl_valid = (sel >= SEL_TBL) && (raw_idx < 8'(NPINS));
        tbl_hi    = sel[0];
        tbl_idx   = raw_idx[IDX_W-1:0];
    end
endmodule

// File: rtl/regwin_table.sv
`timescale 1ns/1ps
module regwin_table #(
    parameter int NPINS = 24,
    parameter int IDX_W = $clog2(NPINS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [31:0]           wdata,
    input  logic                  rset_valid,
    input  logic [IDX_W-1:0]      rset_idx,
    output logic [NPINS*64-1:0]   ent_flat
);
    import regwin_pkg::*;

    logic [63:0] ent_q [NPINS];

    for (genvar g = 0; g < NPINS; g++) begin : g_ent
        logic hit_w;
        logic hit_r;
        assign hit_w = (wr_idx == IDX_W'(g));
        assign hit_r = rset_valid && (rset_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= ENT_RESET;
            end else begin
                if (wr_hi && hit_w)
                    ent_q[g][63:32] <= wdata;
                if (wr_lo && hit_w)
                    ent_q[g][31:0] <= {wdata[31:BIT_RPEND+1], 1'b0, wdata[BIT_RPEND-1:0]};
                else if (hit_r)
                    ent_q[g][BIT_RPEND] <= 1'b1;
            end
        end

        assign ent_flat[g*64 +: 64] = ent_q[g];
    end
endmodule

// File: rtl/regwin_svc_fsm.sv
`timescale 1ns/1ps
module regwin_svc_fsm #(
    parameter int NPINS = 24,
    parameter int IDX_W = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_wr,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [NPINS-1:0] level_vec,
    input  logic [NPINS-1:0] pin_req,
    output logic             svc_req,
    output logic [IDX_W-1:0] svc_pin
);
    import regwin_pkg::*;

    svc_state_t      state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic            hot;

    assign hot = level_vec[idx_q] && pin_req[idx_q];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SV_IDLE:  state_d = tbl_wr ? SV_CHECK : SV_IDLE;
            SV_CHECK: state_d = hot ? SV_FIRE : (tbl_wr ? SV_CHECK : SV_IDLE);
            SV_FIRE:  state_d = tbl_wr ? SV_CHECK : SV_IDLE;
            default:  state_d = SV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SV_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (tbl_wr && !(state_q == SV_CHECK && hot))
                idx_q <= wr_idx;
        end
    end

    always_comb begin
        svc_req = (state_q == SV_FIRE);
        svc_pin = idx_q;
    end
endmodule

// File: rtl/irq_regwin.sv
`timescale 1ns/1ps
module irq_regwin #(
    parameter int         NPINS    = 24,
    parameter int         ADDR_W   = 12,
    parameter logic [7:0] VER_CODE = 8'h20,
    localparam int        IDX_W    = $clog2(NPINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic [1:0]          bus_len,
    output logic [31:0]         bus_rdata,
    input  logic [NPINS-1:0]    pin_req,
    input  logic                rset_valid,
    input  logic [IDX_W-1:0]    rset_idx,
    output logic [NPINS*64-1:0] ent_flat,
    output logic                svc_req,
    output logic [IDX_W-1:0]    svc_pin
);
    import regwin_pkg::*;

    logic [7:0]       sel_q;
    logic [3:0]       id_q;
    logic [7:0]       offs;
    logic [31:0]      wdata_m;
    logic             hit_sel, hit_win, wr_win;
    logic             is_id, is_ver, is_arb, tbl_valid, tbl_hi;
    logic [IDX_W-1:0] tbl_idx;
    logic             wr_lo, wr_hi;
    logic [NPINS-1:0] level_vec;
    logic [63:0]      ent_sel;
    logic [31:0]      rd_raw;

    assign offs    = bus_addr[7:0];
    assign wdata_m = bus_wdata & len_mask(bus_len);
    assign hit_sel = (offs == OFS_SEL);
    assign hit_win = (offs == OFS_WIN);
    assign wr_win  = bus_valid && bus_write && hit_win;
    assign wr_lo   = wr_win && tbl_valid && !tbl_hi;
    assign wr_hi   = wr_win && tbl_valid && tbl_hi;

    regwin_decode #(.NPINS(NPINS), .IDX_W(IDX_W)) u_dec (
        .sel(sel_q), .is_id(is_id), .is_ver(is_ver), .is_arb(is_arb),
        .tbl_valid(tbl_valid), .tbl_hi(tbl_hi), .tbl_idx(tbl_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
        end else begin
            if (bus_valid && bus_write && hit_sel)
                sel_q <= wdata_m[7:0];
            if (wr_win && is_id)
                id_q <= wdata_m[27:24];
        end
    end

    regwin_table #(.NPINS(NPINS), .IDX_W(IDX_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_idx(tbl_idx), .wdata(wdata_m), .rset_valid(rset_valid),
        .rset_idx(rset_idx), .ent_flat(ent_flat)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_lvl
        assign level_vec[g] = ent_flat[g*64 + BIT_LEVEL];
    end

    regwin_svc_fsm #(.NPINS(NPINS), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tbl_wr(wr_lo || wr_hi), .wr_idx(tbl_idx),
        .level_vec(level_vec), .pin_req(pin_req),
        .svc_req(svc_req), .svc_pin(svc_pin)
    );

    assign ent_sel = ent_flat[int'(tbl_idx)*64 +: 64];

    always_comb begin
        rd_raw = '0;
        if (hit_sel)
            rd_raw = {24'h0, sel_q};
        else if (hit_win) begin
            if (is_id || is_arb)
                rd_raw = {4'h0, id_q, 24'h0};
            else if (is_ver)
                rd_raw = {8'h0, 8'(NPINS - 1), 8'h0, VER_CODE};
            else if (tbl_valid)
                rd_raw = tbl_hi ? ent_sel[63:32] : ent_sel[31:0];
            else
                rd_raw = 32'hFFFF_FFFF;
        end
        bus_rdata = rd_raw & len_mask(bus_len);
    end
endmodule

// File: rtl/regwin_checker.sv
`timescale 1ns/1ps
module regwin_checker #(
    parameter int NPINS  = 24,
    parameter int ADDR_W = 12,
    parameter int IDX_W  = $clog2(NPINS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_valid,
    input logic                bus_write,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_wdata,
    input logic                rset_valid,
    input logic [7:0]          sel_q,
    input logic [3:0]          id_q,
    input logic                tbl_valid,
    input logic                tbl_hi,
    input logic [IDX_W-1:0]    tbl_idx,
    input logic [NPINS*64-1:0] ent_flat,
    input logic                svc_req,
    input logic [IDX_W-1:0]    svc_pin
);
    logic             wr_any, wr_win;
    logic [IDX_W-1:0] idx_d;
    logic [63:0]      ent_prev_idx, ent_svc;

    assign wr_any = bus_valid && bus_write;
    assign wr_win = wr_any && (bus_addr[7:0] == 8'h10);

    always_ff @(posedge clk) idx_d <= tbl_idx;
    assign ent_prev_idx = ent_flat[int'(idx_d)*64 +: 64];
    assign ent_svc      = ent_flat[int'(svc_pin)*64 +: 64];

    p_sel_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any && bus_addr[7:0] == 8'h00 |=> sel_q == $past(bus_wdata[7:0]));

    p_ver_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_win && sel_q == 8'h01 && !rset_valid |=> $stable(id_q) && $stable(ent_flat));

    p_arb_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_win && sel_q == 8'h02 |=> $stable(id_q));

    p_oob_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_win && !tbl_valid && sel_q > 8'h02 && !rset_valid
        |=> $stable(ent_flat) && $stable(id_q));

    p_rpend_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_win && tbl_valid && !tbl_hi |=> !ent_prev_idx[14]);

    p_svc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |=> !svc_req);

    p_svc_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> ent_svc[15]);

    p_foreign_ofs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any && bus_addr[7:0] != 8'h00 && bus_addr[7:0] != 8'h10 && !rset_valid
        |=> $stable(sel_q) && $stable(id_q) && $stable(ent_flat));
endmodule

bind irq_regwin regwin_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rset_valid(rset_valid),
    .sel_q(sel_q), .id_q(id_q), .tbl_valid(tbl_valid), .tbl_hi(tbl_hi),
    .tbl_idx(tbl_idx), .ent_flat(ent_flat), .svc_req(svc_req), .svc_pin(svc_pin)
);

// File: tb/test_irq_regwin.sv
`timescale 1ns/1ps
module test_irq_regwin;
    localparam int NP = 24;
    localparam int IW = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [1:0]        bus_len = 2'd2;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     pin_req = '0;
    logic              rset_valid = 1'b0;
    logic [IW-1:0]     rset_idx = '0;
    logic [NP*64-1:0]  ent_flat;
    logic              svc_req;
    logic [IW-1:0]     svc_pin;

    int n_run = 0, n_fail = 0;
    int svc_cnt = 0;
    int last_pin = -1;
    logic [63:0] m_ent [NP];
    logic [3:0]  m_id;

    irq_regwin i_irq_regwin (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_len(bus_len),
        .bus_rdata(bus_rdata), .pin_req(pin_req), .rset_valid(rset_valid),
        .rset_idx(rset_idx), .ent_flat(ent_flat), .svc_req(svc_req), .svc_pin(svc_pin)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n && svc_req) begin
        svc_cnt++;
        last_pin = int'(svc_pin);
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] l);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_len = l;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] l, output logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_len = l;
        #1 v = bus_rdata;
        bus_valid = 1'b0;
    endtask

    function automatic logic [31:0] exp_win(input int s);
        int idx;
        if (s == 0 || s == 2) return {4'h0, m_id, 24'h0};
        if (s == 1) return 32'h0017_0020;
        if (s < 16) return 32'hFFFF_FFFF;
        idx = (s - 16) >> 1;
        if (idx >= NP) return 32'hFFFF_FFFF;
        return (s % 2 == 1) ? m_ent[idx][63:32] : m_ent[idx][31:0];
    endfunction

    function automatic string tag_of(input int s);
        if (s == 1) return "R2";
        if (s == 0 || s == 2) return "R3";
        if (s < 16 || ((s - 16) >> 1) >= NP) return "R5";
        return "R4";
    endfunction

    task automatic win_rd(input int s, input logic [1:0] l, output logic [31:0] v);
        wr(12'h000, 32'(s), 2'd2);
        rd(12'h010, l, v);
    endtask

    task automatic sweep;
        logic [31:0] v;
        for (int s = 0; s < 256; s++) begin
            win_rd(s, 2'd2, v);
            chk(tag_of(s), v, exp_win(s));
        end
    endtask

    task automatic tbl_wr(input int idx, input bit hi, input logic [31:0] d);
        wr(12'h000, 32'(16 + 2*idx + (hi ? 1 : 0)), 2'd2);
        wr(12'h010, d, 2'd2);
        if (hi) m_ent[idx][63:32] = d;
        else    m_ent[idx][31:0]  = d & ~32'h0000_4000;
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int c0;
        for (int i = 0; i < NP; i++) m_ent[i] = 64'h0000_0000_0001_0000;
        m_id = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state: select zero, full sweep of reset contents
        rd(12'h000, 2'd2, v); chk("R8 select", v, 32'h0);
        sweep();

        // R4/R6 fill every entry, low pattern carries bit 14
        for (int i = 0; i < NP; i++) begin
            tbl_wr(i, 1'b0, 32'h0001_4000 | 32'(i) | (32'(i) << 24));
            tbl_wr(i, 1'b1, (32'(i + 8'h40) << 24) | 32'(i * 3));
        end
        chk("R7 no service with pins idle", 32'(svc_cnt), 32'h0);

        // R5 out of range writes, R2/R3 read-only writes
        wr(12'h000, 32'h40, 2'd2); wr(12'h010, 32'h0, 2'd2);
        wr(12'h000, 32'h41, 2'd2); wr(12'h010, 32'h0, 2'd2);
        wr(12'h000, 32'hFF, 2'd2); wr(12'h010, 32'h0, 2'd2);
        wr(12'h000, 32'h05, 2'd2); wr(12'h010, 32'h0, 2'd2);
        wr(12'h000, 32'h01, 2'd2); wr(12'h010, 32'hFFFF_FFFF, 2'd2);
        wr(12'h000, 32'h02, 2'd2); wr(12'h010, 32'h0F00_0000, 2'd2);
        sweep();

        // R3 identification write
        wr(12'h000, 32'h00, 2'd2); wr(12'h010, 32'hF500_0000, 2'd2);
        m_id = 4'h5;
        win_rd(0, 2'd2, v); chk("R3 id", v, 32'h0500_0000);
        win_rd(2, 2'd2, v); chk("R3 arb mirror", v, 32'h0500_0000);

        // R10 length handling
        wr(12'h000, 32'h0F00_0000, 2'd1);
        win_rd(0, 2'd2, v); chk("R10 masked id write", v, 32'h0500_0000);
        wr(12'h000, 32'h0000_AB77, 2'd0);
        rd(12'h000, 2'd2, v); chk("R1/R10 byte select write", v, 32'h77);
        wr(12'h000, 32'h16, 2'd2); wr(12'h010, 32'hFFFF_FFFF, 2'd0);
        m_ent[3][31:0] = 32'h0000_00FF;
        rd(12'h010, 2'd1, v); chk("R10 half read", v, 32'h0000_00FF);
        win_rd(1, 2'd0, v); chk("R10 byte read version", v, 32'h20);
        win_rd(1, 2'd1, v); chk("R10 half read version", v, 32'h20);

        // R9 decode width and foreign offsets
        wr(12'h100, 32'h22, 2'd2);
        rd(12'h300, 2'd2, v); chk("R9 alias select", v, 32'h22);
        wr(12'h020, 32'hFF, 2'd2);
        wr(12'h004, 32'hFF, 2'd2);
        rd(12'h000, 2'd2, v); chk("R9 foreign write ignored", v, 32'h22);
        rd(12'h004, 2'd2, v); chk("R9 foreign read", v, 32'h0);
        rd(12'h0F0, 2'd2, v); chk("R9 foreign read", v, 32'h0);
        sweep();

        // R7 service sequencing
        pin_req = (NP'(1) << 5) | (NP'(1) << 7);
        c0 = svc_cnt;
        wr(12'h000, 32'h1A, 2'd2);
        wr(12'h010, 32'h0000_8033, 2'd2);
        m_ent[5][31:0] = 32'h0000_8033;
        chk("R7 idle one cycle after write", 32'(svc_req), 32'h0);
        @(negedge clk);
        chk("R7 request two cycles after write", 32'(svc_req), 32'h1);
        chk("R7 pin", 32'(svc_pin), 32'd5);
        @(negedge clk);
        chk("R7 single cycle", 32'(svc_req), 32'h0);
        chk("R7 count", 32'(svc_cnt - c0), 32'd1);
        tbl_wr(7, 1'b0, 32'h0000_0044);
        tbl_wr(6, 1'b0, 32'h0000_8055);
        repeat (3) @(negedge clk);
        chk("R7 edge or idle pin no request", 32'(svc_cnt - c0), 32'd1);
        tbl_wr(5, 1'b1, 32'h0300_0000);
        repeat (3) @(negedge clk);
        chk("R7 high half write also requests", 32'(svc_cnt - c0), 32'd2);
        chk("R7 last pin", 32'(last_pin), 32'd5);
        pin_req = '0;

        // R6 remote-pending set and clear
        @(negedge clk); rset_valid = 1'b1; rset_idx = 5'd5;
        @(negedge clk); rset_valid = 1'b0;
        m_ent[5][14] = 1'b1;
        win_rd(16 + 10, 2'd2, v); chk("R6 set", v, m_ent[5][31:0]);
        tbl_wr(5, 1'b1, 32'h0400_0000);
        win_rd(16 + 10, 2'd2, v); chk("R6 high write keeps", v, 32'h0000_C033);
        tbl_wr(5, 1'b0, 32'h0001_4033);
        win_rd(16 + 10, 2'd2, v); chk("R6 low write clears", v, 32'h0001_0033);
        sweep();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule